// File: doc/BRIEF.md
# Dark-Frame Fixed-Pattern Noise Canceller

This block cleans a progressive video channel of the static, position-dependent offsets a CMOS sensor leaves in every frame. It keeps one black value per pixel in an external reference store. The offsets grow with longer integration times, so they cannot be removed with one global constant. One instance serves one colour channel, and a three-channel camera uses three instances.

The block has two modes. A calibration is requested while the lens is capped. At the next start-of-frame the block captures 2^k consecutive black frames. The first frame overwrites the store. Each later frame is added to the stored value through a read-modify-write. During the last frame the running sum is shifted right by k as it is written, so the store ends up holding the per-pixel average. In run mode each incoming pixel reads its own reference word from the store and has it subtracted, with the result floored at zero. Until the first calibration finishes, pixels pass through unchanged.

The store is reached through a synchronous port. Reads return data one cycle after the request, and reads and writes have separate addresses. Corrected pixels leave the block two cycles after they enter.

Top module: `fpn_canceller`

## Requirements
- R1: The store address of a pixel is line*H_PIX + column. A pixel marked start-of-frame has address 0. A pixel marked end-of-line ends its line, so the next pixel is column 0 of the following line. The read for a pixel is issued in the same cycle the pixel is presented.
- R2: Each valid input pixel produces exactly one output pixel, two clock cycles later. Before any calibration has completed, the output value equals the input value.
- R3: A calibrate request is latched and takes effect at the first start-of-frame pixel presented in a later cycle. A request given in the same cycle as a start-of-frame pixel starts calibration at the frame after that one.
- R4: A calibration covers 2^k frames, where k is the frame-count setting captured with the request. Settings above 4 are treated as 4. Afterwards, store word a holds floor(sum of the 2^k black samples at a / 2^k).
- R5: After a completed calibration, run-mode output is max(pixel - reference, 0), using the reference word at that pixel's address.
- R6: The done flag is 0 after reset. It falls when a calibration starts and rises after the final pixel of the last calibration frame. It then stays high until the next calibration starts.
- R7: During calibration frames the output carries the raw input pixel.
- R8: A calibrate request made while a calibration is in progress is ignored. After that calibration, frames are corrected and no new calibration begins.
- R9: The first frame of a calibration overwrites the store, so the new reference does not depend on any previous reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_sof | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| pix_data | input | PIX_W | Input pixel sample |
| cal_req | input | 1 | One-cycle calibration request |
| cal_log2n | input | LOG2N_W | log2 of frames to average (clamped to MAX_LOG2N) |
| cal_done | output | 1 | Reference valid and calibration complete |
| out_valid | output | 1 | Output pixel qualifier |
| out_data | output | PIX_W | Corrected or passed pixel |
| mem_rd_en | output | 1 | Store read request |
| mem_rd_addr | output | ADDR_W | Store read address |
| mem_rd_data | input | ACC_W | Store read data, one cycle after request |
| mem_wr_en | output | 1 | Store write enable |
| mem_wr_addr | output | ADDR_W | Store write address |
| mem_wr_data | output | ACC_W | Store write data |

## Verification
The bench sweeps every frame-count setting on a 4x3 raster, including the setting above the maximum that must clamp to 16 frames, and compares every store word with the arithmetic average. A design that shifted on the wrong frame, or that failed to clamp, would leave sums or over-divided values in the store. Run frames use pixels both brighter and darker than the reference. A design that wrapped on underflow would output values near 1023 where 0 is expected. The bench also checks that a request arriving together with a start-of-frame does not start calibration on that frame, that a request made during calibration is dropped, and that the latency stays at two cycles across idle gaps. A design that misaligned the read data with the pixel, or that started an extra calibration, would show raw or shifted values in the frames that follow.

// File: rtl/fpn_pkg.sv
package fpn_pkg;

    // Per-pixel operation chosen when the pixel enters the pipeline.
    typedef enum logic [1:0] {
        OP_PASS = 2'd0,
        OP_CORR = 2'd1,
        OP_CAL  = 2'd2
    } op_e;

    typedef enum logic {
        MODE_RUN = 1'b0,
        MODE_CAL = 1'b1
    } mode_e;

endpackage

// File: rtl/fpn_raster_addr.sv
module fpn_raster_addr #(
    parameter int H_PIX   = 1920,
    parameter int V_LINES = 1080,
    parameter int ADDR_W  = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_valid,
    input  logic              pix_sof,
    input  logic              pix_eol,
    output logic [ADDR_W-1:0] pix_addr,
    output logic              frame_end
);
    localparam int COL_W     = (H_PIX > 1) ? $clog2(H_PIX) : 1;
    localparam int LINE_W    = (V_LINES > 1) ? $clog2(V_LINES) : 1;
    localparam int FRAME_PIX = H_PIX * V_LINES;

    typedef struct packed {
        logic [COL_W-1:0]  col;
        logic [LINE_W-1:0] line;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [COL_W-1:0]  cur_col;
    logic [LINE_W-1:0] cur_line;

    always_comb begin
        cur_col   = pix_sof ? '0 : pos_q.col;
        cur_line  = pix_sof ? '0 : pos_q.line;
        pix_addr  = ADDR_W'(cur_line) * ADDR_W'(H_PIX) + ADDR_W'(cur_col);
        frame_end = pix_valid && pix_eol && (cur_line == LINE_W'(V_LINES - 1));
        pos_d     = pos_q;
        if (pix_valid) begin
            if (pix_eol) begin
                pos_d.col  = '0;
                pos_d.line = frame_end ? '0 : cur_line + 1'b1;
            end else begin
                pos_d.col  = cur_col + 1'b1;
                pos_d.line = cur_line;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (pix_addr < ADDR_W'(FRAME_PIX))); // R1

endmodule

// File: rtl/fpn_cal_ctrl.sv
module fpn_cal_ctrl
    import fpn_pkg::*;
#(
    parameter int LOG2N_W   = 3,
    parameter int MAX_LOG2N = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic               pix_sof,
    input  logic               frame_end,
    input  logic               cal_req,
    input  logic [LOG2N_W-1:0] cal_log2n,
    output op_e                pix_op,
    output logic               first_frame,
    output logic               last_frame,
    output logic [LOG2N_W-1:0] shift,
    output logic               rd_req,
    output logic               done
);
    localparam int FRM_W = (MAX_LOG2N > 0) ? MAX_LOG2N : 1;

    typedef struct packed {
        mode_e              mode;
        logic               pend;
        logic [LOG2N_W-1:0] log2n;
        logic [FRM_W-1:0]   frm;
        logic               done;
        logic               refv;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic             start;
    logic             in_cal;
    logic [FRM_W-1:0] cur_frm;
    logic [FRM_W-1:0] frm_last;

    always_comb begin
        start    = (st_q.mode == MODE_RUN) && st_q.pend && pix_valid && pix_sof;
        in_cal   = start || (st_q.mode == MODE_CAL);
        frm_last = FRM_W'((1 << st_q.log2n) - 1);
        if (start)
            cur_frm = '0;
        else if ((st_q.mode == MODE_CAL) && pix_valid && pix_sof)
            cur_frm = st_q.frm + 1'b1;
        else
            cur_frm = st_q.frm;

        first_frame = (cur_frm == '0);
        last_frame  = (cur_frm == frm_last);
        shift       = st_q.log2n;
        done        = st_q.done;
        if (in_cal)         pix_op = OP_CAL;
        else if (st_q.refv) pix_op = OP_CORR;
        else                pix_op = OP_PASS;
        rd_req = pix_valid && ((in_cal && !first_frame) || (!in_cal && st_q.refv));

        st_d = st_q;
        if (cal_req && (st_q.mode == MODE_RUN) && !start) begin
            st_d.pend  = 1'b1;
            st_d.log2n = (cal_log2n > LOG2N_W'(MAX_LOG2N)) ? LOG2N_W'(MAX_LOG2N) : cal_log2n;
        end
        if (start) begin
            st_d.mode = MODE_CAL;
            st_d.pend = 1'b0;
            st_d.done = 1'b0;
        end
        if (in_cal && pix_valid) begin
            st_d.frm = cur_frm;
            if (frame_end && last_frame) begin
                st_d.mode = MODE_RUN;
                st_d.done = 1'b1;
                st_d.refv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_DONE_AFTER_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.done) |-> ($past(st_q.mode) == MODE_CAL)); // R6

    AST_REQ_DROPPED_IN_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_CAL) |=> !st_q.pend); // R8

    AST_FRAME_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MODE_CAL) |-> (st_q.frm <= frm_last)); // R4

    AST_LOG2N_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.log2n <= LOG2N_W'(MAX_LOG2N)); // R4

endmodule

// File: rtl/fpn_pix_datapath.sv
module fpn_pix_datapath
    import fpn_pkg::*;
#(
    parameter int PIX_W   = 10,
    parameter int ACC_W   = 14,
    parameter int ADDR_W  = 21,
    parameter int LOG2N_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic [PIX_W-1:0]   pix_data,
    input  logic [ADDR_W-1:0]  pix_addr,
    input  op_e                pix_op,
    input  logic               first_frame,
    input  logic               last_frame,
    input  logic [LOG2N_W-1:0] shift,
    input  logic [ACC_W-1:0]   mem_rd_data,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_data,
    output logic               wr_en,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [ACC_W-1:0]   wr_data
);
    localparam logic [ACC_W-1:0] PIX_MAX = ACC_W'((1 << PIX_W) - 1);

    typedef struct packed {
        logic               valid;
        op_e                op;
        logic               first;
        logic               last;
        logic [LOG2N_W-1:0] shift;
        logic [PIX_W-1:0]   pix;
        logic [ADDR_W-1:0]  addr;
    } stage_t;

    typedef struct packed {
        logic               o_valid;
        logic [PIX_W-1:0]   o_data;
        logic               w_en;
        logic [ADDR_W-1:0]  w_addr;
        logic [ACC_W-1:0]   w_data;
    } outreg_t;

    stage_t  s1_d, s1_q;
    outreg_t ob_d, ob_q;
    logic [ACC_W-1:0] pix_ext;
    logic [ACC_W-1:0] sum;
    logic [ACC_W-1:0] cal_word;
    logic [PIX_W-1:0] corr;

    always_comb begin
        s1_d.valid = pix_valid;
        s1_d.op    = pix_op;
        s1_d.first = first_frame;
        s1_d.last  = last_frame;
        s1_d.shift = shift;
        s1_d.pix   = pix_data;
        s1_d.addr  = pix_addr;

        pix_ext  = ACC_W'(s1_q.pix);
        sum      = (s1_q.first ? '0 : mem_rd_data) + pix_ext;
        cal_word = s1_q.last ? (sum >> s1_q.shift) : sum;
        corr     = (mem_rd_data > pix_ext) ? '0 : PIX_W'(pix_ext - mem_rd_data);

        ob_d.o_valid = s1_q.valid;
        ob_d.o_data  = (s1_q.op == OP_CORR) ? corr : s1_q.pix;
        ob_d.w_en    = s1_q.valid && (s1_q.op == OP_CAL);
        ob_d.w_addr  = s1_q.addr;
        ob_d.w_data  = cal_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            ob_q <= '0;
        end else begin
            s1_q <= s1_d;
            ob_q <= ob_d;
        end
    end

    assign out_valid = ob_q.o_valid;
    assign out_data  = ob_q.o_data;
    assign wr_en     = ob_q.w_en;
    assign wr_addr   = ob_q.w_addr;
    assign wr_data   = ob_q.w_data;

    AST_SAT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && (s1_q.op == OP_CORR)) |=> (out_data <= $past(s1_q.pix))); // R5

    AST_AVG_IN_PIX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && (s1_q.op == OP_CAL) && s1_q.last) |=> (wr_data <= PIX_MAX)); // R4

    AST_RAW_DURING_CAL: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_q.valid && (s1_q.op == OP_CAL)) |=> (out_data == $past(s1_q.pix))); // R7

endmodule

// File: rtl/fpn_canceller.sv
module fpn_canceller
    import fpn_pkg::*;
#(
    parameter int PIX_W     = 10,
    parameter int ACC_W     = 14,
    parameter int H_PIX     = 1920,
    parameter int V_LINES   = 1080,
    parameter int LOG2N_W   = 3,
    parameter int MAX_LOG2N = 4,
    parameter int ADDR_W    = $clog2(H_PIX * V_LINES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pix_valid,
    input  logic               pix_sof,
    input  logic               pix_eol,
    input  logic [PIX_W-1:0]   pix_data,
    input  logic               cal_req,
    input  logic [LOG2N_W-1:0] cal_log2n,
    output logic               cal_done,
    output logic               out_valid,
    output logic [PIX_W-1:0]   out_data,
    output logic               mem_rd_en,
    output logic [ADDR_W-1:0]  mem_rd_addr,
    input  logic [ACC_W-1:0]   mem_rd_data,
    output logic               mem_wr_en,
    output logic [ADDR_W-1:0]  mem_wr_addr,
    output logic [ACC_W-1:0]   mem_wr_data
);
    logic [ADDR_W-1:0]  pix_addr;
    logic               frame_end;
    op_e                pix_op;
    logic               first_frame;
    logic               last_frame;
    logic [LOG2N_W-1:0] shift;

    fpn_raster_addr #(
        .H_PIX  (H_PIX),
        .V_LINES(V_LINES),
        .ADDR_W (ADDR_W)
    ) u_raster (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_valid(pix_valid),
        .pix_sof  (pix_sof),
        .pix_eol  (pix_eol),
        .pix_addr (pix_addr),
        .frame_end(frame_end)
    );

    fpn_cal_ctrl #(
        .LOG2N_W  (LOG2N_W),
        .MAX_LOG2N(MAX_LOG2N)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_sof    (pix_sof),
        .frame_end  (frame_end),
        .cal_req    (cal_req),
        .cal_log2n  (cal_log2n),
        .pix_op     (pix_op),
        .first_frame(first_frame),
        .last_frame (last_frame),
        .shift      (shift),
        .rd_req     (mem_rd_en),
        .done       (cal_done)
    );

    fpn_pix_datapath #(
        .PIX_W  (PIX_W),
        .ACC_W  (ACC_W),
        .ADDR_W (ADDR_W),
        .LOG2N_W(LOG2N_W)
    ) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .pix_addr   (pix_addr),
        .pix_op     (pix_op),
        .first_frame(first_frame),
        .last_frame (last_frame),
        .shift      (shift),
        .mem_rd_data(mem_rd_data),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .wr_en      (mem_wr_en),
        .wr_addr    (mem_wr_addr),
        .wr_data    (mem_wr_data)
    );

    assign mem_rd_addr = pix_addr;

endmodule

// File: tb/fpn_canceller_bench.sv
module fpn_canceller_bench;
    localparam int H    = 4;
    localparam int V    = 3;
    localparam int NPIX = H * V;
    localparam int PW   = 10;
    localparam int AW   = 14;
    localparam int ADW  = $clog2(NPIX);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pix_valid = 1'b0, pix_sof = 1'b0, pix_eol = 1'b0;
    logic [PW-1:0] pix_data = '0;
    logic          cal_req = 1'b0;
    logic [2:0]    cal_log2n = '0;
    logic          cal_done, out_valid, mem_rd_en, mem_wr_en;
    logic [PW-1:0] out_data;
    logic [ADW-1:0] mem_rd_addr, mem_wr_addr;
    logic [AW-1:0] mem_rd_data = '0, mem_wr_data;
    logic [AW-1:0] mem [NPIX];

    int nchk = 0, nerr = 0, cyc = 0;
    int exp_val_q[$], exp_cyc_q[$], exp_tag_q[$];
    int ref_m[NPIX];
    bit refv = 1'b0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    fpn_canceller #(.PIX_W(PW), .ACC_W(AW), .H_PIX(H), .V_LINES(V)) u_fpn_canceller (
        .clk(clk), .rst_n(rst_n), .pix_valid(pix_valid), .pix_sof(pix_sof),
        .pix_eol(pix_eol), .pix_data(pix_data), .cal_req(cal_req), .cal_log2n(cal_log2n),
        .cal_done(cal_done), .out_valid(out_valid), .out_data(out_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data));

    // External reference store: synchronous read, one-cycle latency.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
    end

    task automatic chk(input string tag, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Output monitor: value and two-cycle latency (R2).
    always @(negedge clk) begin
        if (rst_n && out_valid && !finished) begin
            if (exp_val_q.size() == 0) begin
                chk("R2 unexpected output", 1, 0);
            end else begin
                int ev, ec, et;
                ev = exp_val_q.pop_front();
                ec = exp_cyc_q.pop_front();
                et = exp_tag_q.pop_front();
                chk($sformatf("R%0d pixel value", et), int'(out_data), ev);
                chk("R2 latency", cyc - ec, 2);
            end
        end
    end

    function automatic int dark_px(input int seed, input int a);
        return (seed * 13 + a * 29) % 64 + a * 3;
    endfunction

    function automatic int live_px(input int seed, input int a);
        return (a * 53 + seed * 7) % 160;
    endfunction

    // mode: 0 raw expected, 1 corrected expected. req_at: index where cal_req pulses (-1 none).
    task automatic send_frame(input int seed, input bit dark, input bit corr,
                              input int tag, input int req_at);
        for (int a = 0; a < NPIX; a++) begin
            int pv, ev;
            if (a % 5 == 2) begin
                pix_valid = 1'b0;
                cal_req   = 1'b0;
                @(negedge clk);
            end
            pv = dark ? dark_px(seed, a) : live_px(seed, a);
            if (corr) ev = (pv > ref_m[a]) ? pv - ref_m[a] : 0;
            else      ev = pv;
            pix_valid = 1'b1;
            pix_sof   = (a == 0);
            pix_eol   = (a % H == H - 1);
            pix_data  = PW'(pv);
            cal_req   = (a == req_at);
            exp_val_q.push_back(ev);
            exp_cyc_q.push_back(cyc);
            exp_tag_q.push_back(tag);
            @(negedge clk);
        end
        pix_valid = 1'b0;
        pix_sof   = 1'b0;
        pix_eol   = 1'b0;
        cal_req   = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Calibration of 2^k frames (k clamped to 4), started by a separate pulse
    // or already pending. A mid-frame request during frame 0 must be dropped (R8).
    task automatic calibrate(input int kset, input int seed0, input bit pulse);
        int k, n;
        k = (kset > 4) ? 4 : kset;
        n = 1 << k;
        if (pulse) begin
            cal_log2n = 3'(kset);
            cal_req   = 1'b1;
            @(negedge clk);
            cal_req   = 1'b0;
            idle(2);
        end
        for (int f = 0; f < n; f++) begin
            send_frame(seed0 + f, 1'b1, 1'b0, 7, (f == 0) ? 6 : -1); // R7 raw during cal
            if (f == 0 && n > 1) chk("R6 done low during calibration", int'(cal_done), 0);
        end
        idle(4);
        chk("R6 done high after calibration", int'(cal_done), 1);
        for (int a = 0; a < NPIX; a++) begin
            int s;
            s = 0;
            for (int f = 0; f < n; f++) s += dark_px(seed0 + f, a);
            ref_m[a] = s >> k;
            chk($sformatf("R4 store word %0d (k=%0d) R9", a, kset), int'(mem[a]), ref_m[a]);
        end
        refv = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL R2 watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        for (int a = 0; a < NPIX; a++) begin
            mem[a]   = '0;
            ref_m[a] = 0;
        end
        idle(3);
        chk("R6 done after reset", int'(cal_done), 0);
        chk("R2 out_valid after reset", int'(out_valid), 0);
        chk("R2 no write after reset", int'(mem_wr_en), 0);
        rst_n = 1'b1;
        idle(2);

        // R2: passthrough before any calibration.
        send_frame(1, 1'b0, 1'b0, 2, -1);
        idle(3);

        // R3: request together with sof does not calibrate this frame.
        cal_log2n = 3'd1;
        send_frame(2, 1'b0, 1'b0, 3, 0);
        chk("R3 done stays low until cal", int'(cal_done), 0);
        idle(2);
        calibrate(1, 20, 1'b0);

        // R5 and R1: per-position correction, saturating at zero.
        send_frame(10, 1'b0, 1'b1, 5, -1);
        send_frame(11, 1'b0, 1'b1, 1, -1);

        // R4 sweep of frame-count settings, including a clamped one.
        for (int ks = 0; ks < 6; ks++) begin
            if (ks == 1) continue;
            calibrate(ks, 40 + ks * 17, 1'b1);
            // R8: the request dropped during calibration leaves run mode intact.
            send_frame(60 + ks, 1'b0, 1'b1, 8, -1);
            idle(4);
            chk("R8 done still high after dropped request", int'(cal_done), 1);
        end

        idle(6);
        chk("R2 all outputs delivered", exp_val_q.size(), 0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule